// File: doc/BRIEF.md
# MII Receive Preamble and Event Checker

This block watches a nibble-wide media-independent receive interface and judges every reception at the level of physical events. It follows the preamble of each reception, finds the start-of-frame delimiter, and counts nibbles. It records error strobes, carrier events seen between receptions, receptions that are too short or too long, and an odd number of data nibbles. Two configuration inputs make it stricter about the preamble. With `cfg_pure_pre` set, any preamble nibble other than 5 rejects the reception. With `cfg_long_pre` set, a preamble of more than 22 nibbles (11 bytes) rejects it.

When the data-valid strobe falls, the block pulses `frm_done` for one clock. At the same edge it loads a 16-bit status word and a drop flag, and both hold until the next reception ends. A downstream receive path uses `frm_drop` to discard the frame and copies `frm_status` into its per-frame descriptor.

The control is one state machine with four states:
- `ST_IDLE`: no reception.
- `ST_PRE`: inside the preamble.
- `ST_DATA`: the delimiter has been found.
- `ST_DROP`: the preamble was rejected.

Its transitions are:
- start: `ST_IDLE` to `ST_PRE` on the first valid nibble.
- delimiter: `ST_IDLE` or `ST_PRE` to `ST_DATA` when a D nibble follows a 5 nibble.
- reject: `ST_IDLE` or `ST_PRE` to `ST_DROP` on an impure or over-long preamble.
- end: any state to `ST_IDLE` when the valid strobe is low.

Top module: `rxchk_top`

## Requirements
- R1: After reset, `frm_done` and `frm_drop` are 0 and `frm_status` is 16'h0000.
- R2: Suppose the valid strobe is first sampled low at clock edge k after a reception. Then `frm_done` is 1 for exactly the cycle after edge k. `frm_status` and `frm_drop` then hold their values until the next reception ends.
- R3: The delimiter is a 4'hD nibble directly after a 4'h5 nibble. Consider a reception with a pure preamble, the delimiter, at least 64 nibbles in total, an even number of data nibbles and no error strobe. It reports status 16'h8000, where bit 15 means received intact, and drop 0.
- R4: With `cfg_pure_pre` = 1, a nibble other than 4'h5 before the delimiter rejects the reception. The result is drop 1 and status bit 12 set (dropped or long event), with bit 15 clear.
- R5: With `cfg_pure_pre` = 0, non-5 preamble nibbles are ignored and the delimiter search continues, so the reception can still report 16'h8000.
- R6: With `cfg_long_pre` = 1, a reception with more than 22 nibbles before the delimiter's D nibble is rejected (drop 1, bit 12). A reception with exactly 22 such nibbles is accepted.
- R7: With `cfg_long_pre` = 0, preamble length never rejects a reception.
- R8: A reception of more than 12500 nibbles (50,000 bit times) sets bit 12 and clears bit 15, without drop. A reception of exactly 12500 nibbles does not set bit 12.
- R9: The error strobe high while valid is high sets bit 3 (code violation) and clears bit 15.
- R10: Error strobe 1, valid 0 and data 4'hE in any one cycle is a carrier event. It sets bit 2 in the status of the next reception to end, and the bit is then cleared. The error strobe while idle with any other data value has no effect. Bit 2 does not clear bit 15.
- R11: A reception of fewer than 64 nibbles in total sets bit 1 (short event) and clears bit 15. Exactly 64 nibbles is not short.
- R12: An odd number of nibbles after the delimiter sets bit 14 (alignment error) and clears bit 15.
- R13: A reception that ends without a delimiter and without rejection reports bit 15 clear and drop 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock, one nibble per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rxd | input | 4 | Receive data nibble |
| rxdv | input | 1 | Receive data valid |
| rxer | input | 1 | Receive error strobe |
| cfg_pure_pre | input | 1 | Reject receptions whose preamble is not all 4'h5 |
| cfg_long_pre | input | 1 | Reject receptions whose preamble exceeds 22 nibbles |
| frm_done | output | 1 | One-cycle pulse when a reception has ended |
| frm_drop | output | 1 | Reception was rejected during its preamble |
| frm_status | output | 16 | Event status word of the last reception |

## Verification
The bench targets the edges of each counter. It uses preambles of 22 and 23 nibbles, totals of 63, 64 and 12500 against 12501 and more nibbles, and odd against even data counts. A comparison off by one in any of these flips bit 1, bit 12 or bit 14, or wrongly raises the drop flag. An impure first nibble is sent with the purity option both on and off; a design that ignores the option either drops good traffic or passes bad preambles. A carrier event between receptions must appear in exactly one status word: a design that never clears it leaks bit 2 into the following frame, and one that samples it only in-frame loses it. A reception with no delimiter must not claim to be intact.

// File: rtl/rxchk_pkg.sv
package rxchk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_DATA = 2'd2,
        ST_DROP = 2'd3
    } rx_state_e;

    localparam int unsigned STAT_W  = 16;
    localparam int unsigned NIB_W   = 4;

    localparam int unsigned B_SHORT = 1;
    localparam int unsigned B_CARR  = 2;
    localparam int unsigned B_CODEV = 3;
    localparam int unsigned B_LONG  = 12;
    localparam int unsigned B_ALIGN = 14;
    localparam int unsigned B_OK    = 15;

    localparam logic [NIB_W-1:0] NIB_PRE  = 4'h5;
    localparam logic [NIB_W-1:0] NIB_SFD  = 4'hD;
    localparam logic [NIB_W-1:0] NIB_CARR = 4'hE;

endpackage

// File: rtl/rxchk_pre_fsm.sv
module rxchk_pre_fsm
    import rxchk_pkg::*;
#(
    parameter int unsigned MAX_PRE_NIB = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NIB_W-1:0] rxd,
    input  logic             rxdv,
    input  logic             cfg_pure_pre,
    input  logic             cfg_long_pre,
    output logic             frame_end,
    output logic             data_nib,
    output logic             end_sfd,
    output logic             end_drop
);

    localparam int unsigned SAT_CNT = MAX_PRE_NIB + 1;
    localparam int unsigned CNT_W   = $clog2(SAT_CNT + 1);

    rx_state_e        state_q, state_d;
    logic [CNT_W-1:0] pre_cnt_q, pre_cnt_d;
    logic             five_q, five_d;

    logic [CNT_W-1:0] eff_cnt;
    logic             eff_five;
    logic             sfd_hit;
    logic             bad_nib;
    logic             over_len;
    logic             reject;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            pre_cnt_q <= '0;
            five_q    <= 1'b0;
        end else begin
            state_q   <= state_d;
            pre_cnt_q <= pre_cnt_d;
            five_q    <= five_d;
        end
    end

    // next-state logic
    always_comb begin
        eff_cnt   = (state_q == ST_IDLE) ? '0 : pre_cnt_q;
        eff_five  = (state_q == ST_IDLE) ? 1'b0 : five_q;
        sfd_hit   = eff_five && (rxd == NIB_SFD);
        bad_nib   = (rxd != NIB_PRE);
        over_len  = (eff_cnt >= CNT_W'(MAX_PRE_NIB));
        reject    = (cfg_pure_pre && bad_nib) || (cfg_long_pre && over_len);
        state_d   = state_q;
        pre_cnt_d = pre_cnt_q;
        five_d    = five_q;
        if (!rxdv) begin
            state_d   = ST_IDLE;
            pre_cnt_d = '0;
            five_d    = 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_PRE: begin
                    if (sfd_hit) begin
                        state_d = ST_DATA;
                    end else if (reject) begin
                        state_d = ST_DROP;
                    end else begin
                        state_d   = ST_PRE;
                        pre_cnt_d = (eff_cnt == CNT_W'(SAT_CNT)) ? eff_cnt : eff_cnt + 1'b1;
                        five_d    = !bad_nib;
                    end
                end
                ST_DATA: state_d = ST_DATA;
                ST_DROP: state_d = ST_DROP;
            endcase
        end
    end

    // outputs
    always_comb begin
        frame_end = (state_q != ST_IDLE) && !rxdv;
        data_nib  = (state_q == ST_DATA) && rxdv;
        end_sfd   = (state_q == ST_DATA);
        end_drop  = (state_q == ST_DROP);
    end

    // R3: the data state is only entered right after a valid D nibble
    a_r3_sfd_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_DATA) |-> ($past(rxd) == NIB_SFD && $past(rxdv)));

    // R4 / R6: rejection needs one of the two options
    a_r4_drop_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_DROP) |-> $past(cfg_pure_pre || cfg_long_pre));

    // R2: a low valid strobe always returns the machine to idle
    a_r2_idle_on_end: assert property (@(posedge clk) disable iff (!rst_n)
        !rxdv |=> (state_q == ST_IDLE));

endmodule

// File: rtl/rxchk_tally.sv
module rxchk_tally
    import rxchk_pkg::*;
#(
    parameter int unsigned MIN_NIB  = 64,
    parameter int unsigned LONG_NIB = 12500
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NIB_W-1:0] rxd,
    input  logic             rxdv,
    input  logic             rxer,
    input  logic             frame_end,
    input  logic             data_nib,
    output logic             short_ev,
    output logic             long_ev,
    output logic             odd_ev,
    output logic             codev_ev,
    output logic             carr_ev
);

    localparam int unsigned TOT_SAT = LONG_NIB + 1;
    localparam int unsigned TOT_W   = $clog2(TOT_SAT + 1);

    logic [TOT_W-1:0] tot_q;
    logic             odd_q;
    logic             codev_q;
    logic             carr_q;
    logic             carr_set;

    assign carr_set = !rxdv && rxer && (rxd == NIB_CARR);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tot_q   <= '0;
            odd_q   <= 1'b0;
            codev_q <= 1'b0;
            carr_q  <= 1'b0;
        end else begin
            if (frame_end) begin
                tot_q   <= '0;
                odd_q   <= 1'b0;
                codev_q <= 1'b0;
            end else if (rxdv) begin
                if (tot_q != TOT_W'(TOT_SAT)) begin
                    tot_q <= tot_q + 1'b1;
                end
                if (data_nib) begin
                    odd_q <= !odd_q;
                end
                if (rxer) begin
                    codev_q <= 1'b1;
                end
            end
            carr_q <= carr_set || (carr_q && !frame_end);
        end
    end

    always_comb begin
        short_ev = (tot_q < TOT_W'(MIN_NIB));
        long_ev  = (tot_q > TOT_W'(LONG_NIB));
        odd_ev   = odd_q;
        codev_ev = codev_q;
        carr_ev  = carr_q;
    end

    // R9: an in-frame error strobe is remembered
    a_r9_codev_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rxdv && rxer) |=> codev_q);

    // R10: a carrier event is captured for the next report
    a_r10_carrier_capture: assert property (@(posedge clk) disable iff (!rst_n)
        carr_set |=> carr_q);

    // R11: a nibble count only grows during a reception
    a_r11_count_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!rxdv && !frame_end) |=> $stable(tot_q));

endmodule

// File: rtl/rxchk_top.sv
module rxchk_top
    import rxchk_pkg::*;
#(
    parameter int unsigned MAX_PRE_NIB = 22,
    parameter int unsigned MIN_NIB     = 64,
    parameter int unsigned LONG_NIB    = 12500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NIB_W-1:0]  rxd,
    input  logic              rxdv,
    input  logic              rxer,
    input  logic              cfg_pure_pre,
    input  logic              cfg_long_pre,
    output logic              frm_done,
    output logic              frm_drop,
    output logic [STAT_W-1:0] frm_status
);

    logic frame_end, data_nib, end_sfd, end_drop;
    logic short_ev, long_ev, odd_ev, codev_ev, carr_ev;

    logic              done_q;
    logic              drop_q;
    logic [STAT_W-1:0] stat_q;
    logic [STAT_W-1:0] stat_d;

    rxchk_pre_fsm #(
        .MAX_PRE_NIB (MAX_PRE_NIB)
    ) pre_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .rxd          (rxd),
        .rxdv         (rxdv),
        .cfg_pure_pre (cfg_pure_pre),
        .cfg_long_pre (cfg_long_pre),
        .frame_end    (frame_end),
        .data_nib     (data_nib),
        .end_sfd      (end_sfd),
        .end_drop     (end_drop)
    );

    rxchk_tally #(
        .MIN_NIB  (MIN_NIB),
        .LONG_NIB (LONG_NIB)
    ) tally_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rxd       (rxd),
        .rxdv      (rxdv),
        .rxer      (rxer),
        .frame_end (frame_end),
        .data_nib  (data_nib),
        .short_ev  (short_ev),
        .long_ev   (long_ev),
        .odd_ev    (odd_ev),
        .codev_ev  (codev_ev),
        .carr_ev   (carr_ev)
    );

    always_comb begin
        stat_d          = '0;
        stat_d[B_SHORT] = short_ev;
        stat_d[B_CARR]  = carr_ev;
        stat_d[B_CODEV] = codev_ev;
        stat_d[B_LONG]  = long_ev || end_drop;
        stat_d[B_ALIGN] = odd_ev;
        stat_d[B_OK]    = end_sfd && !short_ev && !codev_ev && !long_ev && !odd_ev;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            drop_q <= 1'b0;
            stat_q <= '0;
        end else begin
            done_q <= frame_end;
            if (frame_end) begin
                drop_q <= end_drop;
                stat_q <= stat_d;
            end
        end
    end

    assign frm_done   = done_q;
    assign frm_drop   = drop_q;
    assign frm_status = stat_q;

    // R2: the completion strobe lasts one cycle
    a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R2: outputs only change with a completion
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_q |-> ($stable(stat_q) && $stable(drop_q)));

    // R4: a rejected reception is never reported intact
    a_r4_drop_not_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && drop_q) |-> (!stat_q[B_OK] && stat_q[B_LONG]));

endmodule

// File: tb/rxchk_top_tb_top.sv
module rxchk_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rxd = 4'h0;
    logic        rxdv = 1'b0;
    logic        rxer = 1'b0;
    logic        cfg_pure_pre = 1'b1;
    logic        cfg_long_pre = 1'b1;
    logic        frm_done;
    logic        frm_drop;
    logic [15:0] frm_status;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    rxchk_top dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .rxd          (rxd),
        .rxdv         (rxdv),
        .rxer         (rxer),
        .cfg_pure_pre (cfg_pure_pre),
        .cfg_long_pre (cfg_long_pre),
        .frm_done     (frm_done),
        .frm_drop     (frm_drop),
        .frm_status   (frm_status)
    );

    // {req[3:0], pre_n[7:0], bad, data_n[15:0], er, pure, long, status[15:0], drop}
    localparam int NV = 11;
    localparam logic [48:0] VEC [0:NV-1] = '{
        {4'd3,  8'd15, 1'b0, 16'd100, 1'b0, 1'b1, 1'b1, 16'h8000, 1'b0}, // R3 clean frame
        {4'd4,  8'd15, 1'b1, 16'd100, 1'b0, 1'b1, 1'b1, 16'h1000, 1'b1}, // R4 impure rejected
        {4'd5,  8'd15, 1'b1, 16'd100, 1'b0, 1'b0, 1'b1, 16'h8000, 1'b0}, // R5 impure tolerated
        {4'd6,  8'd22, 1'b0, 16'd60,  1'b0, 1'b1, 1'b1, 16'h8000, 1'b0}, // R6 22 nibbles ok
        {4'd6,  8'd23, 1'b0, 16'd60,  1'b0, 1'b1, 1'b1, 16'h1000, 1'b1}, // R6 23 nibbles dropped
        {4'd7,  8'd23, 1'b0, 16'd60,  1'b0, 1'b1, 1'b0, 16'h8000, 1'b0}, // R7 long allowed
        {4'd9,  8'd15, 1'b0, 16'd100, 1'b1, 1'b1, 1'b1, 16'h0008, 1'b0}, // R9 code violation
        {4'd11, 8'd15, 1'b0, 16'd20,  1'b0, 1'b1, 1'b1, 16'h0002, 1'b0}, // R11 short
        {4'd11, 8'd15, 1'b0, 16'd48,  1'b0, 1'b1, 1'b1, 16'h8000, 1'b0}, // R11 exactly 64
        {4'd11, 8'd15, 1'b0, 16'd47,  1'b0, 1'b1, 1'b1, 16'h4002, 1'b0}, // R11 63 nibbles, odd
        {4'd12, 8'd15, 1'b0, 16'd101, 1'b0, 1'b1, 1'b1, 16'h4000, 1'b0}  // R12 odd data
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s act=0x%0h exp=0x%0h", req, what, act, exp);
        end
    endtask

    // drive one reception; returns at the negedge where frm_done should be high
    task automatic send_frame(input int pre_n, input bit bad, input bit sfd,
                              input int data_n, input bit er);
        for (int i = 0; i < pre_n; i++) begin
            @(negedge clk);
            rxdv = 1'b1;
            rxer = 1'b0;
            rxd  = (bad && i == 0) ? 4'h7 : 4'h5;
        end
        if (sfd) begin
            @(negedge clk);
            rxd = 4'hD;
        end
        for (int i = 0; i < data_n; i++) begin
            @(negedge clk);
            rxd  = 4'hA ^ i[3:0];
            rxer = er && (i == 0);
        end
        @(negedge clk);
        rxdv = 1'b0;
        rxer = 1'b0;
        rxd  = 4'h0;
        @(negedge clk);
    endtask

    task automatic finish_frame(input string req, input int exp_stat, input int exp_drop);
        chk("R2", "done", int'(frm_done), 1);
        chk(req, "status", int'(frm_status), exp_stat);
        chk(req, "drop", int'(frm_drop), exp_drop);
        repeat (3) @(negedge clk);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL R2 watchdog act=running exp=finished");
            summary();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1", "done", int'(frm_done), 0);
        chk("R1", "drop", int'(frm_drop), 0);
        chk("R1", "status", int'(frm_status), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", "status after release", int'(frm_status), 0);

        for (int v = 0; v < NV; v++) begin
            logic [48:0] e;
            e = VEC[v];
            cfg_long_pre = e[17];
            cfg_pure_pre = e[18];
            send_frame(int'(e[44:37]), e[36], 1'b1, int'(e[35:20]), e[19]);
            finish_frame($sformatf("R%0d", e[48:45]), int'(e[16:1]), int'(e[0]));
        end
        cfg_pure_pre = 1'b1;
        cfg_long_pre = 1'b1;

        // R2: one-cycle strobe, values held afterwards
        send_frame(15, 1'b0, 1'b1, 21, 1'b0);
        chk("R2", "done", int'(frm_done), 1);
        chk("R2", "status", int'(frm_status), 16'h4002);
        @(negedge clk);
        chk("R2", "done low", int'(frm_done), 0);
        chk("R2", "status held", int'(frm_status), 16'h4002);
        repeat (5) @(negedge clk);
        chk("R2", "status still held", int'(frm_status), 16'h4002);

        // R10: carrier event reported once in the next frame
        @(negedge clk);
        rxer = 1'b1; rxd = 4'hE;
        @(negedge clk);
        rxer = 1'b0; rxd = 4'h0;
        repeat (2) @(negedge clk);
        send_frame(15, 1'b0, 1'b1, 100, 1'b0);
        finish_frame("R10", 16'h8004, 0);
        send_frame(15, 1'b0, 1'b1, 100, 1'b0);
        finish_frame("R10", 16'h8000, 0);
        // R10: idle error strobe with another value is ignored
        @(negedge clk);
        rxer = 1'b1; rxd = 4'h3;
        @(negedge clk);
        rxer = 1'b0; rxd = 4'h0;
        send_frame(15, 1'b0, 1'b1, 100, 1'b0);
        finish_frame("R10", 16'h8000, 0);

        // R13: no delimiter, long preamble allowed
        cfg_long_pre = 1'b0;
        send_frame(70, 1'b0, 1'b0, 0, 1'b0);
        finish_frame("R13", 16'h0000, 0);
        cfg_long_pre = 1'b1;

        // R8: long event boundary
        send_frame(15, 1'b0, 1'b1, 12484, 1'b0);
        finish_frame("R8", 16'h8000, 0);
        send_frame(15, 1'b0, 1'b1, 12500, 1'b0);
        finish_frame("R8", 16'h1000, 0);

        summary();
    end

endmodule